// File: doc/BRIEF.md
# Time-of-Day Counter with Coherent Read Snapshot

This block keeps calendar time in a chain of binary counters: hundredths of a second, seconds, minutes, hours, weekday, date, month and two-digit year. A fractional prescaler turns an oscillator enable (nominally 32.768 kHz) into an exact 100 Hz average tick. A processor reaches the counters through an 8-bit register port with active-low read, write and select strobes. An address latch controlled by ALE lets the port sit on a multiplexed address/data bus. When ALE is held high the latch is transparent and the port works on a plain bus.

Reading the hundredths register copies every counter into a shared snapshot latch in the same cycle. All other time registers are served from that latch, so software reads one consistent instant, however slowly it walks the registers. A tick that lands while any read strobe is active is held in a one-deep pending flag and applied once the strobe ends. Further ticks during the same read are dropped. A command register holds a run bit, which gates every advance, and a test bit, which drives the hundredths counter straight from the oscillator enable.

All bus strobes are sampled on the system clock. Reads and writes act on the falling edge of the strobe, detected synchronously.

Top module: `rtc_snapshot_clock`

## Requirements
- R1: After a synchronous reset every time counter is 0 except date and month, which are 1. The command register is 0, which means stopped, and dout_oe is low.
- R2: While command bit 3 (run) is 0, no counter advances, whatever osc_en does and whatever the state of command bit 5.
- R3: With run=1 and test=0, exactly TICK_HZ hundredths advances happen per OSC_HZ osc_en pulses. With the defaults 100/32768, the first advance follows the 328th pulse and none follows the 327th. The prescaler phase clears while stopped.
- R4: With run=1 and command bit 5 (test)=1, each cycle with osc_en high advances the hundredths counter by one.
- R5: Hundredths wrap 99 to 0, seconds and minutes wrap 59 to 0, and hours wrap 23 to 0, each carrying into the next counter. An hours carry also steps the weekday, which wraps 6 to 0, and the date.
- R6: The date wraps to 1 after 30 in months 4, 6, 9 and 11, after 31 in the other months, and in month 2 after 29 when year mod 4 is 0, otherwise after 28. The wrap carries into the month.
- R7: Month wraps 12 to 1 and carries into the year, which wraps 99 to 0.
- R8: A read of address 0 copies all counters into the snapshot latch. Reads of addresses 0 to 7 return latched values, which stay unchanged until the next read of address 0.
- R9: No counter advances while a read strobe is active. One tick seen during the read is applied in the cycle after the read ends, and any further ticks seen during that read are discarded.
- R10: A register is selected only when the effective select is low. dout_oe is high, and dout carries data, only while rd_n is low and the register is selected; otherwise dout is 0. A write happens on the falling edge of wr_n when the register is selected; a strobe while not selected has no effect.
- R11: While ale is high, addr and cs_n pass straight through to the decode. When ale falls, both are held at their last values until ale rises again.
- R12: The address map is: 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 date, 5 month, 6 year, 7 weekday, 8 command (8 bits, read back as written; bit 3 run, bit 5 test). Time values are plain binary, right-aligned, and unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_en | input | 1 | One-cycle enable per oscillator period |
| ale | input | 1 | Address latch enable; high = transparent |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | AW | Register address (tie to din[4:0] on a multiplexed bus) |
| din | input | DW | Write data |
| dout | output | DW | Registered read data |
| dout_oe | output | 1 | High while read data is driven |

## Verification
The hardest situation to create is a tick arriving during an open read, and then more ticks arriving during that same read. In test mode the oscillator enable is itself the tick, so the bench holds rd_n low on a non-snapshot address and pulses osc_en a chosen number of times. A later snapshot read must show exactly one advance. The prescaler boundary is reached by stopping exactly after 327 and 328 oscillator pulses, then running the full 32768 to check the long-term count.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [6:0] hund;
    logic [5:0] sec;
    logic [5:0] min;
    logic [4:0] hour;
    logic [4:0] date;
    logic [3:0] month;
    logic [6:0] year;
    logic [2:0] wday;
  } rtc_time_t;

  localparam logic [4:0] A_HUND  = 5'd0;
  localparam logic [4:0] A_SEC   = 5'd1;
  localparam logic [4:0] A_MIN   = 5'd2;
  localparam logic [4:0] A_HOUR  = 5'd3;
  localparam logic [4:0] A_DATE  = 5'd4;
  localparam logic [4:0] A_MONTH = 5'd5;
  localparam logic [4:0] A_YEAR  = 5'd6;
  localparam logic [4:0] A_WDAY  = 5'd7;
  localparam logic [4:0] A_CMD   = 5'd8;

  localparam int unsigned RUN_BIT  = 3;
  localparam int unsigned TEST_BIT = 5;

  localparam rtc_time_t TIME_RESET = '{hund: 7'd0, sec: 6'd0, min: 6'd0,
                                       hour: 5'd0, date: 5'd1, month: 4'd1,
                                       year: 7'd0, wday: 3'd0};

  // Last valid date of a month; four-year leap rule on a two-digit year.
  function automatic logic [4:0] last_date(input logic [3:0] m, input logic [6:0] y);
    case (m)
      4'd2:                      last_date = (y[1:0] == 2'b00) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   last_date = 5'd30;
      default:                   last_date = 5'd31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_bus_port.sv
module rtc_bus_port #(
  parameter int unsigned AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ale,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  output logic [AW-1:0] eff_addr,
  output logic          rd_act,
  output logic          rd_fall,
  output logic          wr_fall
);

  logic [AW-1:0] addr_q;
  logic          cs_n_q;
  logic          rd_q;
  logic          wr_q;
  logic          sel;
  logic          wr_act;

  // Transparent while ale is high, holding once it drops.
  assign eff_addr = ale ? addr : addr_q;
  assign sel      = ale ? !cs_n : !cs_n_q;
  assign rd_act   = sel && !rd_n;
  assign wr_act   = sel && !wr_n;
  assign rd_fall  = rd_act && !rd_q;
  assign wr_fall  = wr_act && !wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      cs_n_q <= 1'b1;
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
    end else begin
      if (ale) begin
        addr_q <= addr;
        cs_n_q <= cs_n;
      end
      rd_q <= rd_act;
      wr_q <= wr_act;
    end
  end

endmodule

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen #(
  parameter int unsigned OSC_HZ  = 32768,
  parameter int unsigned TICK_HZ = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic osc_en,
  input  logic run,
  input  logic test,
  input  logic reading,
  output logic advance
);

  localparam int unsigned ACC_W = $clog2(OSC_HZ + TICK_HZ) + 1;
  localparam logic [ACC_W-1:0] OSC_L  = ACC_W'(OSC_HZ);
  localparam logic [ACC_W-1:0] STEP_L = ACC_W'(TICK_HZ);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_sum;
  logic             pre_tick_q;
  logic             pending_q;
  logic             gated;

  assign acc_sum = acc_q + STEP_L;
  assign gated   = run && (test ? osc_en : pre_tick_q);
  assign advance = run && !reading && (pending_q || gated);

  // Fractional divider: average rate is exactly TICK_HZ/OSC_HZ per enable.
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      acc_q      <= '0;
      pre_tick_q <= 1'b0;
    end else if (osc_en && !test) begin
      if (acc_sum >= OSC_L) begin
        acc_q      <= acc_sum - OSC_L;
        pre_tick_q <= 1'b1;
      end else begin
        acc_q      <= acc_sum;
        pre_tick_q <= 1'b0;
      end
    end else begin
      pre_tick_q <= 1'b0;
    end
  end

  // One-deep holdoff: a tick during a read waits; extras in that read are lost.
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pending_q <= 1'b0;
    end else if (reading) begin
      pending_q <= pending_q || gated;
    end else begin
      pending_q <= pending_q && gated;
    end
  end

endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain #(
  parameter int unsigned AW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [6:0]        wr_data,
  output rtc_pkg::rtc_time_t cur
);
  import rtc_pkg::*;

  rtc_time_t inc;
  rtc_time_t nxt;
  logic c_sec, c_min, c_hour, c_day, c_month, c_year;

  always_comb begin
    inc     = cur;
    c_sec   = cur.hund  >= 7'd99;
    c_min   = c_sec   && (cur.sec  >= 6'd59);
    c_hour  = c_min   && (cur.min  >= 6'd59);
    c_day   = c_hour  && (cur.hour >= 5'd23);
    c_month = c_day   && (cur.date >= last_date(cur.month, cur.year));
    c_year  = c_month && (cur.month >= 4'd12);

    inc.hund = c_sec ? 7'd0 : cur.hund + 7'd1;
    if (c_sec)  inc.sec  = c_min  ? 6'd0 : cur.sec  + 6'd1;
    if (c_min)  inc.min  = c_hour ? 6'd0 : cur.min  + 6'd1;
    if (c_hour) inc.hour = c_day  ? 5'd0 : cur.hour + 5'd1;
    if (c_day) begin
      inc.wday = (cur.wday >= 3'd6) ? 3'd0 : cur.wday + 3'd1;
      inc.date = c_month ? 5'd1 : cur.date + 5'd1;
    end
    if (c_month) inc.month = c_year ? 4'd1 : cur.month + 4'd1;
    if (c_year)  inc.year  = (cur.year >= 7'd99) ? 7'd0 : cur.year + 7'd1;
  end

  // A bus write overrides only the addressed field in the same cycle.
  always_comb begin
    nxt = advance ? inc : cur;
    if (wr_en) begin
      case (wr_addr)
        AW'(A_HUND):  nxt.hund  = wr_data;
        AW'(A_SEC):   nxt.sec   = wr_data[5:0];
        AW'(A_MIN):   nxt.min   = wr_data[5:0];
        AW'(A_HOUR):  nxt.hour  = wr_data[4:0];
        AW'(A_DATE):  nxt.date  = wr_data[4:0];
        AW'(A_MONTH): nxt.month = wr_data[3:0];
        AW'(A_YEAR):  nxt.year  = wr_data;
        AW'(A_WDAY):  nxt.wday  = wr_data[2:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cur <= TIME_RESET;
    else     cur <= nxt;
  end

endmodule

// File: rtl/rtc_snapshot_clock.sv
module rtc_snapshot_clock #(
  parameter int unsigned OSC_HZ  = 32768,
  parameter int unsigned TICK_HZ = 100,
  parameter int unsigned AW      = 5,
  parameter int unsigned DW      = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          osc_en,
  input  logic          ale,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_oe
);
  import rtc_pkg::*;

  logic [AW-1:0] eff_addr;
  logic          rd_act, rd_fall, wr_fall;
  logic          wr_ctr, wr_cmd, snap_evt;
  logic          advance;
  logic [7:0]    cmd_q;
  logic          cmd_run, cmd_test;
  rtc_time_t     cur_time;
  rtc_time_t     snap_q;
  logic [DW-1:0] rd_mux;

  rtc_bus_port #(.AW(AW)) u_bus (
    .clk(clk), .rst(rst), .ale(ale), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .eff_addr(eff_addr), .rd_act(rd_act), .rd_fall(rd_fall),
    .wr_fall(wr_fall)
  );

  assign wr_ctr   = wr_fall && (eff_addr <= AW'(A_WDAY));
  assign wr_cmd   = wr_fall && (eff_addr == AW'(A_CMD));
  assign snap_evt = rd_fall && (eff_addr == AW'(A_HUND));
  assign cmd_run  = cmd_q[RUN_BIT];
  assign cmd_test = cmd_q[TEST_BIT];

  rtc_tick_gen #(.OSC_HZ(OSC_HZ), .TICK_HZ(TICK_HZ)) u_tick (
    .clk(clk), .rst(rst), .osc_en(osc_en), .run(cmd_run), .test(cmd_test),
    .reading(rd_act), .advance(advance)
  );

  rtc_time_chain #(.AW(AW)) u_chain (
    .clk(clk), .rst(rst), .advance(advance), .wr_en(wr_ctr),
    .wr_addr(eff_addr), .wr_data(din[6:0]), .cur(cur_time)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= '0;
      snap_q <= TIME_RESET;
    end else begin
      if (wr_cmd)   cmd_q  <= din[7:0];
      if (snap_evt) snap_q <= cur_time;
    end
  end

  always_comb begin
    case (eff_addr)
      AW'(A_HUND):  rd_mux = DW'(snap_q.hund);
      AW'(A_SEC):   rd_mux = DW'(snap_q.sec);
      AW'(A_MIN):   rd_mux = DW'(snap_q.min);
      AW'(A_HOUR):  rd_mux = DW'(snap_q.hour);
      AW'(A_DATE):  rd_mux = DW'(snap_q.date);
      AW'(A_MONTH): rd_mux = DW'(snap_q.month);
      AW'(A_YEAR):  rd_mux = DW'(snap_q.year);
      AW'(A_WDAY):  rd_mux = DW'(snap_q.wday);
      AW'(A_CMD):   rd_mux = DW'(cmd_q);
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout    <= '0;
      dout_oe <= 1'b0;
    end else begin
      dout    <= rd_act ? rd_mux : '0;
      dout_oe <= rd_act;
    end
  end

endmodule

// File: rtl/rtc_snapshot_checker.sv
module rtc_snapshot_checker (
  input logic               clk,
  input logic               rst,
  input logic               rd_n,
  input logic               dout_oe,
  input logic               run,
  input logic               reading,
  input logic               advance,
  input logic               wr_ctr,
  input logic               snap_evt,
  input rtc_pkg::rtc_time_t cur,
  input rtc_pkg::rtc_time_t snap
);

  AST_RESET_STOPPED: assert property (@(posedge clk) rst |=> (!run && !dout_oe)); // R1
  AST_STOP_FREEZES: assert property (@(posedge clk) disable iff (rst) (!run && !wr_ctr) |=> $stable(cur)); // R2
  AST_HUND_WRAP: assert property (@(posedge clk) disable iff (rst) (advance && cur.hund == 7'd99 && !wr_ctr) |=> (cur.hund == 7'd0)); // R5
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst) !snap_evt |=> $stable(snap)); // R8
  AST_NO_ADVANCE_IN_READ: assert property (@(posedge clk) disable iff (rst) reading |-> !advance); // R9
  AST_OE_NEEDS_RD: assert property (@(posedge clk) disable iff (rst) dout_oe |-> $past(!rd_n)); // R10

endmodule

bind rtc_snapshot_clock rtc_snapshot_checker u_chk (
  .clk(clk), .rst(rst), .rd_n(rd_n), .dout_oe(dout_oe), .run(cmd_run),
  .reading(rd_act), .advance(advance), .wr_ctr(wr_ctr), .snap_evt(snap_evt),
  .cur(cur_time), .snap(snap_q)
);

// File: tb/rtc_snapshot_clock_bench.sv
module rtc_snapshot_clock_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       osc_en = 1'b0;
  logic       ale = 1'b1;
  logic       cs_n = 1'b1;
  logic       rd_n = 1'b1;
  logic       wr_n = 1'b1;
  logic [4:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic       dout_oe;

  always #10 clk = ~clk;

  rtc_snapshot_clock u_rtc_snapshot_clock (
    .clk(clk), .rst(rst), .osc_en(osc_en), .ale(ale), .cs_n(cs_n),
    .rd_n(rd_n), .wr_n(wr_n), .addr(addr), .din(din), .dout(dout),
    .dout_oe(dout_oe)
  );

  typedef struct {
    logic [7:0] val;
    logic       oe;
    string      req;
  } exp_t;

  exp_t sb_q[$];
  bit   mon_go = 1'b0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  // Monitor: pops the expected item and compares it against the port values.
  always @(negedge clk) begin
    if (mon_go) begin
      exp_t it;
      it = sb_q.pop_front();
      checks++;
      if (dout !== it.val || dout_oe !== it.oe) begin
        errors++;
        $display("FAIL %s: got dout=%0d oe=%0b, expected dout=%0d oe=%0b",
                 it.req, dout, dout_oe, it.val, it.oe);
      end
      mon_go = 1'b0;
    end
  end

  task automatic push(input logic [7:0] v, input logic oe, input string req);
    exp_t it;
    it.val = v; it.oe = oe; it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic sample();
    mon_go = 1'b1;
    wait (mon_go == 1'b0);
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [7:0] d, input logic c = 1'b0);
    @(negedge clk); addr = a; din = d; cs_n = c; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1; cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); osc_en = 1'b1;
      @(negedge clk); osc_en = 1'b0;
    end
  endtask

  // Driver: read with optional ticks while the strobe is held low.
  task automatic rd_exp(input logic [4:0] a, input logic [7:0] v, input string req,
                        input logic oe = 1'b1, input logic c = 1'b0, input int held = 0);
    push(v, oe, req);
    @(negedge clk); addr = a; cs_n = c; rd_n = 1'b0;
    pulse(held);
    repeat (3) @(posedge clk);
    sample();
    @(negedge clk); rd_n = 1'b1; cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic ale_rd(input logic [4:0] la, input logic lc, input logic [4:0] pa,
                        input logic pc, input logic [7:0] v, input logic oe, input string req);
    push(v, oe, req);
    @(negedge clk); ale = 1'b1; addr = la; cs_n = lc;
    @(negedge clk); ale = 1'b0; addr = pa; cs_n = pc; rd_n = 1'b0;
    repeat (3) @(posedge clk);
    sample();
    @(negedge clk); rd_n = 1'b1; cs_n = 1'b1;
    @(negedge clk); ale = 1'b1;
    @(negedge clk);
  endtask

  task automatic set_time(input logic [6:0] y, input logic [3:0] mo, input logic [4:0] d,
                          input logic [4:0] h, input logic [5:0] mi, input logic [5:0] s,
                          input logic [6:0] hu);
    bus_wr(5'd8, 8'h00);
    bus_wr(5'd6, {1'b0, y});  bus_wr(5'd5, {4'b0, mo}); bus_wr(5'd4, {3'b0, d});
    bus_wr(5'd3, {3'b0, h});  bus_wr(5'd2, {2'b0, mi}); bus_wr(5'd1, {2'b0, s});
    bus_wr(5'd0, {1'b0, hu});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1 / R12: reset values through the register map
    rd_exp(5'd0, 8'd0, "R1 hundredths after reset");
    rd_exp(5'd1, 8'd0, "R1 seconds after reset");
    rd_exp(5'd4, 8'd1, "R1 date after reset");
    rd_exp(5'd5, 8'd1, "R1 month after reset");
    rd_exp(5'd8, 8'd0, "R1 command after reset");
    rd_exp(5'd20, 8'd0, "R12 unused address reads 0");
    // R2: stopped, with and without test bit
    pulse(20);
    bus_wr(5'd8, 8'h20);
    pulse(5);
    rd_exp(5'd0, 8'd0, "R2 stopped counters frozen");
    // R4 / R12: test mode, command readback
    bus_wr(5'd8, 8'h28);
    rd_exp(5'd8, 8'h28, "R12 command readback");
    pulse(7);
    rd_exp(5'd0, 8'd7, "R4 test mode counts osc_en");
    // R5 / R7: full rollover of every field
    set_time(7'd99, 4'd12, 5'd31, 5'd23, 6'd59, 6'd59, 7'd98);
    bus_wr(5'd7, 8'd6);
    bus_wr(5'd8, 8'h28);
    pulse(1);
    rd_exp(5'd0, 8'd99, "R5 hundredths to 99");
    pulse(1);
    rd_exp(5'd0, 8'd0, "R5 hundredths wrap");
    rd_exp(5'd1, 8'd0, "R5 seconds wrap");
    rd_exp(5'd2, 8'd0, "R5 minutes wrap");
    rd_exp(5'd3, 8'd0, "R5 hours wrap");
    rd_exp(5'd7, 8'd0, "R5 weekday wrap 6 to 0");
    rd_exp(5'd4, 8'd1, "R6 date wrap after 31");
    rd_exp(5'd5, 8'd1, "R7 month wrap 12 to 1");
    rd_exp(5'd6, 8'd0, "R7 year wrap 99 to 0");
    // R6: leap February, then March
    set_time(7'd4, 4'd2, 5'd28, 5'd23, 6'd59, 6'd59, 7'd99);
    bus_wr(5'd8, 8'h28); pulse(1);
    rd_exp(5'd0, 8'd0, "R6 snapshot");
    rd_exp(5'd4, 8'd29, "R6 leap February reaches 29");
    set_time(7'd4, 4'd2, 5'd29, 5'd23, 6'd59, 6'd59, 7'd99);
    bus_wr(5'd8, 8'h28); pulse(1);
    rd_exp(5'd0, 8'd0, "R6 snapshot");
    rd_exp(5'd4, 8'd1, "R6 leap February wraps after 29");
    rd_exp(5'd5, 8'd3, "R6 month after February");
    set_time(7'd5, 4'd2, 5'd28, 5'd23, 6'd59, 6'd59, 7'd99);
    bus_wr(5'd8, 8'h28); pulse(1);
    rd_exp(5'd0, 8'd0, "R6 snapshot");
    rd_exp(5'd4, 8'd1, "R6 common February wraps after 28");
    set_time(7'd5, 4'd4, 5'd30, 5'd23, 6'd59, 6'd59, 7'd99);
    bus_wr(5'd8, 8'h28); pulse(1);
    rd_exp(5'd0, 8'd0, "R6 snapshot");
    rd_exp(5'd5, 8'd5, "R6 April wraps after 30");
    // R8: snapshot coherence
    set_time(7'd0, 4'd1, 5'd1, 5'd0, 6'd0, 6'd5, 7'd10);
    bus_wr(5'd8, 8'h28);
    rd_exp(5'd0, 8'd10, "R8 snapshot hundredths");
    pulse(150);
    rd_exp(5'd1, 8'd5, "R8 seconds held in latch");
    rd_exp(5'd0, 8'd60, "R8 new snapshot hundredths");
    rd_exp(5'd1, 8'd6, "R8 new snapshot seconds");
    // R9: ticks during a held read
    rd_exp(5'd1, 8'd6, "R9 data steady during held read", 1'b1, 1'b0, 3);
    rd_exp(5'd0, 8'd61, "R9 one deferred tick, extras dropped");
    rd_exp(5'd1, 8'd6, "R9 single held tick", 1'b1, 1'b0, 1);
    rd_exp(5'd0, 8'd62, "R9 single deferred tick applied");
    // R3: prescaler
    set_time(7'd0, 4'd1, 5'd1, 5'd0, 6'd0, 6'd0, 7'd0);
    bus_wr(5'd8, 8'h08);
    @(negedge clk); osc_en = 1'b1;
    repeat (327) @(negedge clk);
    osc_en = 1'b0;
    rd_exp(5'd0, 8'd0, "R3 no tick after 327 pulses");
    pulse(1);
    rd_exp(5'd0, 8'd1, "R3 tick after 328th pulse");
    @(negedge clk); osc_en = 1'b1;
    repeat (32440) @(negedge clk);
    osc_en = 1'b0;
    bus_wr(5'd8, 8'h00);
    rd_exp(5'd0, 8'd0, "R3 100 ticks per 32768 pulses (hundredths)");
    rd_exp(5'd1, 8'd1, "R3 100 ticks per 32768 pulses (seconds)");
    // R10: select gating
    rd_exp(5'd0, 8'd0, "R10 no drive when deselected", 1'b0, 1'b1);
    bus_wr(5'd0, 8'd55, 1'b1);
    rd_exp(5'd0, 8'd0, "R10 deselected write ignored");
    // R11: address and select latch
    ale_rd(5'd1, 1'b0, 5'd2, 1'b1, 8'd1, 1'b1, "R11 latched address and select");
    ale_rd(5'd0, 1'b1, 5'd0, 1'b0, 8'd0, 1'b0, "R11 latched deselect");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule